// File: doc/BRIEF.md
# Passive Monochrome LCD Line Formatter

This block drives a monochrome passive-matrix LCD panel from a byte-wide frame buffer. It reads bytes through a simple fetch port, cuts them into 4- or 8-bit groups of pixels, and presents each group on an 8-bit pixel bus together with a shift clock. After the last group of a line it issues a one-cycle line latch pulse. It also provides a frame start pulse, an AC-drive waveform that toggles once per frame, and a registered panel enable.

Three layouts are supported. The first is a 4-bit single panel. The second is an 8-bit single panel. The third is a dual panel, where the top and bottom halves of the screen are scanned at the same time: the top half goes on the upper nibble and the bottom half on the lower nibble. Every frame ends with two retrace line periods. These lines carry blank data and cause no fetches.

The fetch port is read combinationally. The block places an address on `fetch_addr` with `fetch_en` high, and the byte must be present on `fetch_data` in that same cycle. Within each byte, bit 7 is the leftmost pixel.

Top module: `lcd_panel_fmt`

## Requirements
- R1: While `rst` is high, `shift_clk`, `line_latch`, `frame_start`, `ac_wave`, `lcd_en` and `pix_out` are all 0 at the next clock edge and stay 0.
- R2: `lcd_en` equals `panel_on` delayed by one clock.
- R3: Each transfer holds `shift_clk` high for exactly one cycle, then low for at least one cycle. `pix_out` changes only on the edge where `shift_clk` rises, so it is stable at the falling edge.
- R4: After the last transfer of a line, `line_latch` is high for exactly one cycle with `shift_clk` low. A line occupies 2*`cfg_xfers`+3 cycles, measured from latch pulse to latch pulse.
- R5: A frame has `cfg_rows`+2 latch pulses. The final two lines of each frame shift out `cfg_xfers` transfers of 8'h00 and never raise `fetch_en`.
- R6: `frame_start` is high during the latch pulse of the first line of each frame and low during the latch pulses of all other lines.
- R7: `ac_wave` toggles once per frame, on the same edge where `frame_start` rises. It is 1 during the first frame after reset.
- R8: Mode 2'b00 (4-bit single) uses one byte per two transfers. Row r, transfer k reads byte r*(`cfg_xfers`/2)+k/2. An even k drives bits 7:4 of that byte onto `pix_out[7:4]`; an odd k drives bits 3:0. `pix_out[3:0]` is 0.
- R9: Mode 2'b01 (8-bit single) uses one byte per transfer. Row r, transfer k puts byte r*`cfg_xfers`+k unchanged on `pix_out`: the first four pixels go on `pix_out[7:4]` with the leftmost on bit 7, and the next four go on `pix_out[3:0]`.
- R10: In mode 2'b10 or 2'b11 (dual), row r, transfer k uses top byte T = r*B+k/2 and bottom byte T+`cfg_rows`*B, where B=`cfg_xfers`/2. The nibble of T goes on `pix_out[7:4]` and the same nibble of the bottom byte goes on `pix_out[3:0]`: the high nibble for even k, the low nibble for odd k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Formatter clock |
| rst | input | 1 | Synchronous reset, active high |
| panel_on | input | 1 | Panel enable request (mode control bit) |
| cfg_mode | input | 2 | 00 4-bit single, 01 8-bit single, 1x dual |
| cfg_xfers | input | XW | Shift clocks per line (even in 4-bit and dual modes) |
| cfg_rows | input | YW | Rows scanned per frame (half height in dual mode) |
| fetch_en | output | 1 | Fetch address valid |
| fetch_addr | output | AW | Frame buffer byte address |
| fetch_data | input | 8 | Byte at `fetch_addr`, same cycle |
| shift_clk | output | 1 | Pixel shift clock |
| line_latch | output | 1 | Line latch / row advance pulse |
| frame_start | output | 1 | First-line marker, active high |
| ac_wave | output | 1 | Frame-rate AC drive waveform |
| lcd_en | output | 1 | Registered panel enable |
| pix_out | output | 8 | Upper nibble [7:4], lower nibble [3:0] |

## Verification
Each layout is run with a frame buffer whose byte values depend on the address, so every fetched byte differs from its neighbours. A wrong byte index, a swapped nibble or a wrong half-frame offset therefore shows up as a wrong value on `pix_out`. The 8-bit mode separates byte-per-transfer indexing from the nibble-per-transfer modes. The dual runs at two sizes check that the bottom offset grows with the row count. Latch spacing, the number of lines per frame and the blank retrace data are checked from the same frames. The frame marker and the waveform are checked across one frame boundary.

// File: rtl/lcd_panel_fmt.sv
module lcd_panel_fmt #(
  parameter int AW = 16,
  parameter int XW = 10,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          panel_on,
  input  logic [1:0]    cfg_mode,
  input  logic [XW-1:0] cfg_xfers,
  input  logic [YW-1:0] cfg_rows,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  input  logic [7:0]    fetch_data,
  output logic          shift_clk,
  output logic          line_latch,
  output logic          frame_start,
  output logic          ac_wave,
  output logic          lcd_en,
  output logic [7:0]    pix_out
);
  typedef enum logic [1:0] {S_LEAD, S_XFER, S_LATCH} st_t;

  st_t         st;
  logic        ph;
  logic [XW-1:0] nk;
  logic [YW:0]   ln;
  logic [AW-1:0] base;
  logic [7:0]    hold, hold2;

  logic          mode8, dual, data_line, more, active, last_line;
  logic          get_top, get_bot;
  logic [XW-1:0] bpr;
  logic [AW-1:0] half, idx;
  logic [7:0]    bot_byte, next_pix;

  assign mode8     = (cfg_mode == 2'b01);
  assign dual      = cfg_mode[1];
  assign bpr       = mode8 ? cfg_xfers : (cfg_xfers >> 1);
  assign half      = AW'(cfg_rows) * AW'(bpr);
  assign data_line = ln < {1'b0, cfg_rows};
  assign last_line = ln == ({1'b0, cfg_rows} + 1'b1);
  assign more      = nk < cfg_xfers;
  assign active    = st != S_LATCH;
  assign get_top   = active && !ph && data_line && more && (mode8 || !nk[0]);
  assign get_bot   = active && ph && dual && data_line && more && !nk[0];
  assign idx       = mode8 ? AW'(nk) : AW'(nk >> 1);
  assign fetch_en  = get_top || get_bot;
  assign fetch_addr = base + idx + (get_bot ? half : '0);
  assign bot_byte  = nk[0] ? hold2 : fetch_data;

  function automatic logic [3:0] nib(input logic [7:0] b, input logic lo);
    return lo ? b[3:0] : b[7:4];
  endfunction

  always_comb begin
    if (!data_line)  next_pix = 8'h00;
    else if (mode8)  next_pix = hold;
    else if (dual)   next_pix = {nib(hold, nk[0]), nib(bot_byte, nk[0])};
    else             next_pix = {nib(hold, nk[0]), 4'h0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_LEAD; ph <= 1'b0; nk <= '0; ln <= '0; base <= '0;
      hold <= '0; hold2 <= '0;
      shift_clk <= 1'b0; line_latch <= 1'b0; frame_start <= 1'b0;
      ac_wave <= 1'b0; lcd_en <= 1'b0; pix_out <= '0;
    end else begin
      lcd_en <= panel_on;
      case (st)
        S_LATCH: begin
          line_latch <= 1'b0;
          st <= S_LEAD;
          nk <= '0;
          if (last_line) begin
            ln <= '0; base <= '0;
          end else begin
            ln <= ln + 1'b1;
            if (data_line) base <= base + AW'(bpr);
          end
        end
        default: begin
          if (!ph) begin
            ph <= 1'b1;
            shift_clk <= 1'b0;
            if (get_top) hold <= fetch_data;
            if (st == S_LEAD) begin
              frame_start <= (ln == '0);
              if (ln == '0) ac_wave <= ~ac_wave;
            end
          end else begin
            ph <= 1'b0;
            if (get_bot) hold2 <= fetch_data;
            if (more) begin
              pix_out <= next_pix;
              shift_clk <= 1'b1;
              nk <= nk + 1'b1;
              st <= S_XFER;
            end else begin
              line_latch <= 1'b1;
              st <= S_LATCH;
            end
          end
        end
      endcase
    end
  end

  p_en_low_r1: assert property (@(posedge clk) rst |=> !lcd_en);
  p_pix_stable_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_clk) |-> $stable(pix_out));
  p_latch_single_r4: assert property (@(posedge clk) disable iff (rst)
    line_latch |=> !line_latch);
  p_latch_idle_r4: assert property (@(posedge clk) disable iff (rst)
    line_latch |-> !shift_clk);
  p_wave_toggle_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_start) |-> (ac_wave != $past(ac_wave)));
endmodule

// File: tb/lcd_panel_fmt_bench.sv
module lcd_panel_fmt_bench;
  localparam int AW = 16, XW = 10, YW = 10;
  logic clk = 0, rst = 1, panel_on = 0;
  logic [1:0] cfg_mode = 0;
  logic [XW-1:0] cfg_xfers = 8;
  logic [YW-1:0] cfg_rows = 3;
  logic fetch_en, shift_clk, line_latch, frame_start, ac_wave, lcd_en;
  logic [AW-1:0] fetch_addr;
  logic [7:0] fetch_data, pix_out;

  int checks = 0, fails = 0;
  logic [7:0] expq[$];
  int lpcnt = 0, cyc = 0;
  logic prev_sclk = 0;
  logic [7:0] prev_pix = 0;
  int retrace_fetch = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    logic [AW-1:0] t;
    t = a * 16'd29 + (a >> 8) * 16'd3 + 16'd7;
    return t[7:0];
  endfunction
  assign fetch_data = memf(fetch_addr);

  lcd_panel_fmt #(.AW(AW), .XW(XW), .YW(YW)) u_lcd_panel_fmt (
    .clk(clk), .rst(rst), .panel_on(panel_on), .cfg_mode(cfg_mode),
    .cfg_xfers(cfg_xfers), .cfg_rows(cfg_rows), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data), .shift_clk(shift_clk),
    .line_latch(line_latch), .frame_start(frame_start), .ac_wave(ac_wave),
    .lcd_en(lcd_en), .pix_out(pix_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nb(input logic [7:0] b, input int k);
    return (k % 2) ? b[3:0] : b[7:4];
  endfunction

  task automatic push_frame(input int mode, input int xf, input int rows);
    int bpr;
    bpr = (mode == 1) ? xf : xf / 2;
    for (int r = 0; r < rows + 2; r++)
      for (int k = 0; k < xf; k++) begin
        logic [7:0] e, t, b;
        if (r >= rows) e = 8'h00;
        else if (mode == 1) e = memf(AW'(r * xf + k));
        else if (mode == 0) begin
          t = memf(AW'(r * bpr + k / 2)); e = {nb(t, k), 4'h0};
        end else begin
          t = memf(AW'(r * bpr + k / 2));
          b = memf(AW'(rows * bpr + r * bpr + k / 2));
          e = {nb(t, k), nb(b, k)};
        end
        expq.push_back(e);
      end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      lpcnt <= 0; cyc <= 0; prev_sclk <= 0; prev_pix <= 0;
    end else begin
      int line, frame;
      line = lpcnt % (int'(cfg_rows) + 2);
      frame = lpcnt / (int'(cfg_rows) + 2);
      if (shift_clk) begin
        chk(!prev_sclk, "R3 clock high one cycle", prev_sclk, 0);
        if (expq.size() > 0) begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(pix_out == e, (cfg_mode == 0) ? "R8 4-bit data" :
              (cfg_mode == 1) ? "R9 8-bit data" :
              (line >= int'(cfg_rows)) ? "R5 retrace blank" : "R10 dual data",
              pix_out, e);
        end
      end else
        chk(pix_out == prev_pix, "R3 data changes only on rise", pix_out, prev_pix);
      if (fetch_en && line >= int'(cfg_rows)) retrace_fetch++;
      if (line_latch) begin
        chk(!shift_clk, "R4 clock idle in latch", shift_clk, 0);
        if (lpcnt > 0)
          chk(cyc + 1 == 2 * int'(cfg_xfers) + 3, "R4 line length", cyc + 1,
              2 * int'(cfg_xfers) + 3);
        chk(frame_start == (line == 0), "R6 frame start", frame_start, line == 0);
        if (line == 0)
          chk(ac_wave == ((frame % 2) == 0), "R7 wave per frame", ac_wave,
              (frame % 2) == 0);
        lpcnt <= lpcnt + 1;
        cyc <= 0;
      end else cyc <= cyc + 1;
      prev_sclk <= shift_clk;
      prev_pix <= pix_out;
    end
  end

  task automatic run_case(input int mode, input int xf, input int rows);
    rst = 1; panel_on = 1;
    cfg_mode = 2'(mode); cfg_xfers = XW'(xf); cfg_rows = YW'(rows);
    expq.delete();
    retrace_fetch = 0;
    push_frame(mode, xf, rows);
    repeat (3) @(negedge clk);
    chk({shift_clk, line_latch, frame_start, ac_wave, lcd_en, pix_out} == '0,
        "R1 reset state", {shift_clk, line_latch, frame_start, ac_wave, lcd_en, pix_out}, 0);
    rst = 0; panel_on = 0;
    @(negedge clk);
    chk(lcd_en == 0, "R2 enable follows", lcd_en, 0);
    panel_on = 1;
    @(negedge clk);
    chk(lcd_en == 1, "R2 enable follows", lcd_en, 1);
    while (lpcnt < rows + 3) @(negedge clk);
    chk(expq.size() == 0, "R5 frame transfer count", expq.size(), 0);
    chk(retrace_fetch == 0, "R5 no retrace fetch", retrace_fetch, 0);
  endtask

  initial begin
    run_case(0, 8, 3);
    run_case(1, 6, 4);
    run_case(2, 8, 3);
    run_case(3, 4, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule